// File: doc/BRIEF.md
# Quad Programmable Down-Counter Timer

This block holds four independent down-counters behind a small single-cycle register port. It drives one interrupt line that all four channels share. Each channel has five settings:

- a start value, which is loaded at once;
- a background value, used only at the next wrap;
- a per-channel prescaler of 1, 16 or 256;
- a 16-bit or 32-bit counting width;
- a mode: free-running, periodic reload or one-shot.

Software reads a channel's live count. A rising timebase comes from inverting or negating that count.

Every channel can raise an event bit when it counts from 1 down to 0. The event bits are gathered in a shared raw status word. A mask word picks which of them reach the interrupt line. A write-one-to-clear register acknowledges them. A typical use runs channel 0 free as a timestamp source, and runs channel 1 periodic or one-shot as an event generator.

Top module: `quad_down_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: Addresses are byte offsets.
  - Shared registers: 0x00 is the mask (read/write), 0x04 is raw status, 0x08 is masked status and 0x0C is the clear register. The clear register reads 0.
  - Channel n occupies 0x10+0x10*n: start value at +0x0, live count at +0x4, control at +0x8, background value at +0xC.
  - The live count is read-only, and a write to it has no effect.
  - Read data is registered: it appears after the clock edge that samples `bus_re`, and it holds while `bus_re` is low.
- R3: A write to the start value loads the counter and the background value together. A write to the background value changes only the background value. A disabled channel keeps its count.
- R4: The control fields are:
  - bit 7: enable;
  - bit 6: periodic;
  - bits 3:2: prescale;
  - bit 1: 32-bit width;
  - bit 0: one-shot.

  Bits 5:4 read back 0. The counter does not step in the cycle its control register is written.
- R5: Prescale 00 steps the counter every cycle and 01 steps it every 16 cycles. Prescale 10 or 11 steps it every 256 cycles. The prescaler restarts on a control write, so the first step comes that many cycles after the write.
- R6: In periodic mode (bit 6 set, bit 0 clear), a step from 1 reloads the background value and sets the channel's raw status bit.
- R7: In free-running mode (bits 6 and 0 clear), a step from 1 wraps to 0xFFFF in 16-bit mode or to 0xFFFFFFFF in 32-bit mode, and sets the raw bit. In 16-bit mode the live count reads with bits 31:16 zero.
- R8: In one-shot mode (bit 0 set, whatever bit 6 holds), a step from 1 sets the raw bit, and the count then stays at 0.
- R9: Raw status uses bit n for channel n. Masked status is raw AND mask. `irq_o` is the OR of the masked bits.
- R10: Writing 1 to bit n of the clear register clears raw bit n. If the channel raises its bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt, OR of the masked status bits |

## Verification
Channel 2 is set to count 2, 1, wrap, so its event lands on a known edge. In that same cycle the bench writes that channel's bit to the clear register, which puts a raw-status set and a software clear on the same bit at once. The result is judged from the port: the raw status read afterwards must still show bit 2, and `irq_o` must be high. A separate clear with the channel stopped then shows that the clear works on its own.

// File: rtl/qdt_pkg.sv
// Shared types for the quad down-counter timer.
// Assumes: control byte layout as described in the brief (bit positions are behaviour).
package qdt_pkg;

    localparam int CTRL_W   = 8;
    localparam int EN_BIT   = 7;
    localparam int PER_BIT  = 6;
    localparam int PS_HI    = 3;
    localparam int PS_LO    = 2;
    localparam int WIDE_BIT = 1;
    localparam int ONE_BIT  = 0;

    typedef struct packed {
        logic       en;
        logic       periodic;
        logic [1:0] ps;
        logic       wide;
        logic       oneshot;
    } ctrl_t;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_ONESHOT  = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        CREG_LOAD  = 2'd0,
        CREG_VALUE = 2'd1,
        CREG_CTRL  = 2'd2,
        CREG_BG    = 2'd3
    } creg_e;

    typedef enum logic [1:0] {
        SREG_MASK   = 2'd0,
        SREG_RAW    = 2'd1,
        SREG_MASKED = 2'd2,
        SREG_CLEAR  = 2'd3
    } sreg_e;

endpackage

// File: rtl/qdt_prescaler.sv
// Tick generator for one channel: emits a one-cycle step every 1, 2**MID_SHIFT
// or 2**HI_SHIFT cycles. Assumes sel changes only together with restart.
module qdt_prescaler #(
    parameter int MID_SHIFT = 4,
    parameter int HI_SHIFT  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick_o
);
    localparam int PW = HI_SHIFT;

    logic [PW-1:0] pre_q;
    logic [PW-1:0] limit;

    // Terminal count for the chosen ratio.
    always_comb begin
        case (sel)
            2'b00:   limit = '0;
            2'b01:   limit = PW'((32'd1 << MID_SHIFT) - 32'd1);
            default: limit = '1;
        endcase
    end

    // Divider counter, cleared when stopped, rewritten or at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)                              pre_q <= '0;
        else if (!run || restart || pre_q == limit) pre_q <= '0;
        else                                     pre_q <= pre_q + 1'b1;
    end

    assign tick_o = run && !restart && (pre_q == limit);

endmodule

// File: rtl/qdt_channel.sv
// One down-counter channel: start/background values, control byte, mode logic.
// Assumes CNT_W >= NARROW_W and one register write per cycle at most.
module qdt_channel
    import qdt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int NARROW_W  = 16,
    parameter int MID_SHIFT = 4,
    parameter int HI_SHIFT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic              bg_we,
    input  logic              ctrl_we,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  value_o,
    output logic [CNT_W-1:0]  bg_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              expire_o
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt_q, bg_q, cnt_d;
    logic [CNT_W-1:0] width_mask, eff_cnt, eff_bg;
    logic             tick, expire;
    mode_e            mode;

    qdt_prescaler #(.MID_SHIFT(MID_SHIFT), .HI_SHIFT(HI_SHIFT)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl_q.en),
        .restart(ctrl_we),
        .sel    (ctrl_q.ps),
        .tick_o (tick)
    );

    // Mode decode: one-shot outranks periodic.
    always_comb begin
        if (ctrl_q.oneshot)       mode = MODE_ONESHOT;
        else if (ctrl_q.periodic) mode = MODE_PERIODIC;
        else                      mode = MODE_FREE;
    end

    // Width masking of the live count and reload value.
    always_comb begin
        width_mask = ctrl_q.wide ? '1 : CNT_W'({NARROW_W{1'b1}});
        eff_cnt    = cnt_q & width_mask;
        eff_bg     = bg_q & width_mask;
    end

    // Next count on a prescaled step.
    always_comb begin
        expire = 1'b0;
        cnt_d  = cnt_q;
        if (tick) begin
            if (eff_cnt == CNT_W'(1)) begin
                expire = 1'b1;
                case (mode)
                    MODE_PERIODIC: cnt_d = eff_bg;
                    MODE_FREE:     cnt_d = width_mask;
                    default:       cnt_d = '0;
                endcase
            end else if (eff_cnt == '0) begin
                case (mode)
                    MODE_PERIODIC: cnt_d = eff_bg;
                    MODE_FREE:     cnt_d = width_mask;
                    default:       cnt_d = '0;
                endcase
            end else begin
                cnt_d = eff_cnt - CNT_W'(1);
            end
        end
    end

    // Counter and background value storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bg_q  <= '0;
        end else if (ld_we) begin
            cnt_q <= wdata;
            bg_q  <= wdata;
        end else begin
            cnt_q <= cnt_d;
            if (bg_we) bg_q <= wdata;
        end
    end

    // Control byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (ctrl_we)
            ctrl_q <= '{en: wdata[EN_BIT], periodic: wdata[PER_BIT],
                        ps: wdata[PS_HI:PS_LO], wide: wdata[WIDE_BIT],
                        oneshot: wdata[ONE_BIT]};
    end

    assign value_o  = eff_cnt;
    assign bg_o     = bg_q;
    assign ctrl_o   = {ctrl_q.en, ctrl_q.periodic, 2'b00, ctrl_q.ps, ctrl_q.wide, ctrl_q.oneshot};
    assign expire_o = expire && !ld_we;

    // R6: after a periodic expiry the count shows the prior background value.
    a_r6_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && mode == MODE_PERIODIC && !ctrl_we) |=> (value_o == $past(eff_bg)));

    // R8: a one-shot channel resting at zero stays there.
    a_r8_oneshot_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.en && mode == MODE_ONESHOT && value_o == '0 && !ld_we && !ctrl_we)
        |=> (value_o == '0));

    // R3: a disabled channel keeps its count.
    a_r3_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.en && !ld_we && !ctrl_we) |=> $stable(value_o));

endmodule

// File: rtl/qdt_irq.sv
// Shared interrupt status: raw bits set by channel events, cleared by
// write-one, masked view and OR output. Assumes set outranks clear.
module qdt_irq #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_i,
    input  logic           clr_we,
    input  logic [NCH-1:0] clr_bits,
    input  logic           mask_we,
    input  logic [NCH-1:0] mask_wdata,
    output logic [NCH-1:0] raw_o,
    output logic [NCH-1:0] mask_o,
    output logic [NCH-1:0] masked_o,
    output logic           irq_o
);
    logic [NCH-1:0] raw_q, mask_q, clr_eff;

    assign clr_eff = clr_we ? clr_bits : '0;

    // Raw status update, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_eff) | set_i;
    end

    // Interrupt mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    assign raw_o    = raw_q;
    assign mask_o   = mask_q;
    assign masked_o = raw_q & mask_q;
    assign irq_o    = |masked_o;

    // R10: a raised event is visible next cycle, even under a clear.
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((raw_q & $past(set_i)) == $past(set_i)));

    // R10: a clear with no concurrent event empties those bits.
    a_r10_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_eff & ~set_i)) |=> ((raw_q & $past(clr_eff & ~set_i)) == '0));

endmodule

// File: rtl/quad_down_timer.sv
// Top: address decode, NCH channel instances, shared interrupt status and
// registered read port. Assumes DATA_W == CNT_W and NCH < 2**(ADDR_W-4) - 1.
module quad_down_timer
    import qdt_pkg::*;
#(
    parameter int NCH          = 4,
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 32,
    parameter int NARROW_W     = 16,
    parameter int PS_MID_SHIFT = 4,
    parameter int PS_HI_SHIFT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int BLK_W = ADDR_W - 4;
    localparam int CNT_W = DATA_W;

    logic [BLK_W-1:0] blk;
    logic [1:0]       word;
    logic             shared_sel;
    logic [NCH-1:0]   ch_sel;
    logic             addr_unused;

    logic [CNT_W-1:0]  ch_value [NCH];
    logic [CNT_W-1:0]  ch_bg    [NCH];
    logic [CTRL_W-1:0] ch_ctrl  [NCH];
    logic [NCH-1:0]    ch_expire;
    logic [NCH-1:0]    raw, mask, masked;
    logic [DATA_W-1:0] rd_d;

    assign blk         = bus_addr[ADDR_W-1:4];
    assign word        = bus_addr[3:2];
    assign shared_sel  = (blk == '0);
    assign addr_unused = ^bus_addr[1:0];

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            assign ch_sel[g] = (blk == BLK_W'(g + 1));
            qdt_channel #(
                .CNT_W(CNT_W), .NARROW_W(NARROW_W),
                .MID_SHIFT(PS_MID_SHIFT), .HI_SHIFT(PS_HI_SHIFT)
            ) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .ld_we   (bus_we && ch_sel[g] && word == CREG_LOAD),
                .bg_we   (bus_we && ch_sel[g] && word == CREG_BG),
                .ctrl_we (bus_we && ch_sel[g] && word == CREG_CTRL),
                .wdata   (bus_wdata),
                .value_o (ch_value[g]),
                .bg_o    (ch_bg[g]),
                .ctrl_o  (ch_ctrl[g]),
                .expire_o(ch_expire[g])
            );
        end
    endgenerate

    qdt_irq #(.NCH(NCH)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (ch_expire),
        .clr_we    (bus_we && shared_sel && word == SREG_CLEAR),
        .clr_bits  (bus_wdata[NCH-1:0]),
        .mask_we   (bus_we && shared_sel && word == SREG_MASK),
        .mask_wdata(bus_wdata[NCH-1:0]),
        .raw_o     (raw),
        .mask_o    (mask),
        .masked_o  (masked),
        .irq_o     (irq_o)
    );

    // Read multiplexer over shared and per-channel registers.
    always_comb begin
        rd_d = '0;
        if (shared_sel) begin
            case (word)
                SREG_MASK:   rd_d = DATA_W'(mask);
                SREG_RAW:    rd_d = DATA_W'(raw);
                SREG_MASKED: rd_d = DATA_W'(masked);
                default:     rd_d = '0;
            endcase
        end
        for (int i = 0; i < NCH; i++) begin
            if (ch_sel[i]) begin
                case (word)
                    CREG_LOAD:  rd_d = ch_bg[i];
                    CREG_VALUE: rd_d = ch_value[i];
                    CREG_CTRL:  rd_d = DATA_W'(ch_ctrl[i]);
                    default:    rd_d = ch_bg[i];
                endcase
            end
        end
    end

    // Registered read data, held between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_d;
    end

    // R2: read data only changes on a read strobe.
    a_r2_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

endmodule

// File: tb/test_quad_down_timer.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares them.
module test_quad_down_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    quad_down_timer i_quad_down_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] ca(input int ch, input int w);
        return 8'(8'h10 + 8'h10 * ch + 4 * w);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        bus_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq_o !== e) begin
            fails++;
            $display("FAIL %s: irq got %0b expected %0b", t, irq_o, e);
        end
    endtask

    // Monitor: record read strobes and compare returned data.
    always @(posedge clk) rd_seen <= bus_re;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd(ca(0,2), 32'h0, "R1 ctrl0");
        rd(ca(0,1), 32'h0, "R1 value0");
        rd(8'h04, 32'h0, "R1 raw");
        rd(8'h00, 32'h0, "R1 mask");
        chk_irq(1'b0, "R1 irq");

        // R3/R5: load, persist while disabled, periodic run at /1
        wr(ca(0,0), 32'd100);
        rd(ca(0,3), 32'd100, "R3 bg follows load");
        rd(ca(0,1), 32'd100, "R3 value loaded");
        rd(ca(0,1), 32'd100, "R3 value held while disabled");
        wr(ca(0,2), 32'hC2);
        rd(ca(0,1), 32'd100, "R4 no step on ctrl write");
        rd(ca(0,1), 32'd99, "R5 step every cycle");
        idle(8);
        rd(ca(0,1), 32'd90, "R5 ten steps");
        rd(ca(0,2), 32'hC2, "R4 ctrl readback");
        wr(ca(0,2), 32'h0);

        // R6/R9/R10: periodic reload from background, interrupt, clear
        wr(8'h00, 32'h2);
        wr(ca(1,0), 32'd5);
        wr(ca(1,3), 32'd3);
        rd(ca(1,0), 32'd3, "R3 bg write alone");
        wr(ca(1,2), 32'hC2);
        rd(ca(1,1), 32'd5, "R6 start");
        idle(3);
        rd(ca(1,1), 32'd1, "R6 before expiry");
        chk_irq(1'b1, "R9 irq on masked event");
        rd(ca(1,1), 32'd3, "R6 reload from bg");
        wr(ca(1,2), 32'h0);
        rd(8'h04, 32'h2, "R9 raw bit1");
        rd(8'h08, 32'h2, "R9 masked bit1");
        wr(8'h0C, 32'h2);
        rd(8'h04, 32'h0, "R10 clear");
        chk_irq(1'b0, "R10 irq low after clear");
        rd(ca(1,1), 32'd2, "R3 count kept when disabled");
        rd(8'h0C, 32'h0, "R2 clear reads 0");

        // R7: free-running wrap, 16 and 32 bit
        wr(ca(2,0), 32'h0003_0002);
        wr(ca(2,2), 32'h80);
        rd(ca(2,1), 32'h2, "R7 16-bit view");
        rd(ca(2,1), 32'h1, "R7 step");
        rd(ca(2,1), 32'hFFFF, "R7 16-bit wrap");
        rd(8'h04, 32'h4, "R7 raw bit2");
        chk_irq(1'b0, "R9 unmasked event no irq");
        rd(8'h08, 32'h0, "R9 masked empty");
        wr(ca(2,2), 32'h0);
        wr(ca(2,0), 32'd1);
        wr(ca(2,2), 32'h82);
        rd(ca(2,1), 32'd1, "R7 32-bit start");
        rd(ca(2,1), 32'hFFFF_FFFF, "R7 32-bit wrap");
        wr(ca(2,2), 32'h0);
        wr(8'h0C, 32'hF);

        // R4/R8/R2: reserved bits, one-shot, value register read-only
        wr(ca(3,2), 32'h30);
        rd(ca(3,2), 32'h0, "R4 bits 5:4 read 0");
        wr(ca(3,0), 32'd3);
        wr(8'h00, 32'h8);
        wr(ca(3,2), 32'hC3);
        rd(ca(3,1), 32'd3, "R8 start");
        idle(2);
        rd(ca(3,1), 32'd0, "R8 reached zero");
        chk_irq(1'b1, "R8 event raised");
        idle(3);
        rd(ca(3,1), 32'd0, "R8 holds at zero");
        rd(8'h04, 32'h8, "R8 raw bit3");
        wr(ca(3,1), 32'h1234);
        rd(ca(3,1), 32'd0, "R2 value write ignored");
        wr(8'h0C, 32'h8);
        chk_irq(1'b0, "R10 clear bit3");

        // R10: event and clear on the same edge
        wr(8'h00, 32'h4);
        wr(ca(2,0), 32'd2);
        wr(ca(2,2), 32'h82);
        idle(1);
        wr(8'h0C, 32'h4);
        chk_irq(1'b1, "R10 set wins irq");
        rd(8'h04, 32'h4, "R10 set wins raw");
        wr(ca(2,2), 32'h0);
        wr(8'h0C, 32'h4);
        rd(8'h04, 32'h0, "R10 clear alone");

        // R5: divide by 16
        wr(ca(0,0), 32'd10);
        wr(ca(0,2), 32'h86);
        rd(ca(0,1), 32'd10, "R5 /16 start");
        idle(14);
        rd(ca(0,1), 32'd10, "R5 /16 no step before 16");
        rd(ca(0,1), 32'd9, "R5 /16 step at 16");
        wr(ca(0,2), 32'h0);

        // R5: divide by 256
        wr(ca(1,0), 32'd2);
        wr(ca(1,2), 32'h8A);
        rd(ca(1,1), 32'd2, "R5 /256 start");
        idle(254);
        rd(ca(1,1), 32'd2, "R5 /256 no step before 256");
        rd(ca(1,1), 32'd1, "R5 /256 step at 256");

        idle(3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule